// File: doc/BRIEF.md
# Modulo Timer with Overflow Flag

This block is a 16-bit timer counter that counts between zero and a modulo limit supplied on an input port. An 8-bit status/control register, reached through a simple bus with separate read and write strobes, picks the clock source, the power-of-two prescale divisor and the counting mode. The same register reports and clears an overflow flag. In up-count mode the counter wraps from the limit to zero. In up/down mode it climbs to the limit, turns, and falls back to zero, which gives center-aligned periods.

The clock source is one of three: the bus clock itself, a fixed internal tick pulse, or an external pin. The external pin passes through a synchronizer and a rising-edge detector. The divided tick drives a direction state machine (states `DIR_UP`, `DIR_DOWN`; transitions *turn-down* at the limit in up/down mode, *turn-up* at zero, *force-up* whenever up-count mode is selected). A flag state machine (states `FLG_CLEAR`, `FLG_SET`, `FLG_ARMED`; transitions *overflow* from any state to `FLG_SET`, *arm* on a register read in `FLG_SET`, *clear* on a write of 0 to bit 7 in `FLG_ARMED`) implements the two-step clear. An overflow that arrives during the clear sequence cancels it. The interrupt request is the flag gated by its enable bit.

Top module: `ovf_modulo_timer`

## Requirements
- R1: After reset, the register reads 0x00, the count is 0 and irq is low.
- R2: In up-count mode (bit 5 = 0), each tick adds one to the count until it reaches the limit. The next tick loads 0 and sets the flag (bit 7), in the same cycle that the count shows 0.
- R3: In up/down mode (bit 5 = 1), the count rises to the limit. The next tick loads limit-1 and sets the flag. The count then falls to 0, and the tick after that loads 1.
- R4: A modulo input of 0x0000 acts as a limit of 0xFFFF.
- R5: The flag clears only when a bus read occurs while the flag is set and a later write has bit 7 = 0. A write of 0 with no prior read leaves it set.
- R6: An overflow that occurs after the read and before the write cancels the sequence, so the flag stays set.
- R7: Writing 1 to bit 7 never sets the flag.
- R8: irq is high exactly when the flag is set and the enable (bit 6) is 1.
- R9: Clock select bits 4:3 work as follows. Code 00 freezes the count and restarts the prescaler. Code 01 ticks on every bus clock. Code 10 ticks on each cycle with fixed_tick high. Code 11 ticks once per rising edge of ext_clk, after a two-flop synchronizer.
- R10: Prescale bits 2:0 = p divide the selected source ticks by 2^p.
- R11: Bits 6:0 read back the value last written, in the order bit 6 enable, bit 5 mode, bits 4:3 clock select, bits 2:0 prescale. bus_rdata always shows the current register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Register read strobe (arms the clear sequence) |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current register value |
| modulo | input | 16 | Count limit (0 means 0xFFFF) |
| fixed_tick | input | 1 | Fixed internal clock enable pulse |
| ext_clk | input | 1 | External clock pin, asynchronous |
| count | output | 16 | Current counter value |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that bus_rd and bus_wr are single-cycle, well-defined strobes. They also assume that modulo changes only between accesses, and never in a way that the counter comparisons treat as undefined. The stimulus drives every input at the falling clock edge and holds each strobe for one cycle. It keeps ext_clk low or high for several bus cycles at a time, so that every rising edge survives synchronization. Random modulo values stay small, so that overflows and clear sequences collide often.

// File: rtl/tm_pkg.sv
package tm_pkg;
    typedef enum logic {DIR_UP, DIR_DOWN} dir_t;
    typedef enum logic [1:0] {FLG_CLEAR, FLG_SET, FLG_ARMED} flg_t;
    localparam logic [1:0] SRC_OFF   = 2'b00;
    localparam logic [1:0] SRC_BUS   = 2'b01;
    localparam logic [1:0] SRC_FIXED = 2'b10;
    localparam logic [1:0] SRC_EXT   = 2'b11;
    localparam int FLAG_BIT = 7;
endpackage

// File: rtl/tm_clk_sel.sv
module tm_clk_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       fixed_tick,
    input  logic       ext_pin,
    output logic       src_tick
);
    import tm_pkg::*;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   ext_rise;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else if (i == 0) sync_q[i] <= ext_pin;
                else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else last_q <= sync_q[SYNC_STAGES-1];
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~last_q;

    always_comb begin
        unique case (sel)
            SRC_OFF:   src_tick = 1'b0;
            SRC_BUS:   src_tick = 1'b1;
            SRC_FIXED: src_tick = fixed_tick;
            SRC_EXT:   src_tick = ext_rise;
        endcase
    end

    // R9: disabled source never produces a tick
    a_r9_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_OFF) |-> !src_tick);
endmodule

// File: rtl/tm_prescale.sv
module tm_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            src_tick,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int PRE_W = (1 << PS_W) - 1;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    assign mask = PRE_W'((PRE_W+1)'(1) << ps) - PRE_W'(1);
    assign tick = src_tick && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) pre_q <= '0;
        else if (src_tick) pre_q <= pre_q + PRE_W'(1);
    end

    // R10: a divided tick only happens on a source tick
    a_r10_tick_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> src_tick);
    // R9: prescaler restarts while the source is off
    a_r9_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> pre_q == '0);
endmodule

// File: rtl/tm_counter.sv
module tm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             center,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic             ovf_evt
);
    import tm_pkg::*;
    dir_t             dir_q, dir_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [CNT_W-1:0] top;

    assign top   = (modulo == '0) ? '1 : modulo;
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
            cnt_q <= '0;
        end else begin
            dir_q <= dir_nx;
            cnt_q <= cnt_nx;
        end
    end

    always_comb begin
        dir_nx  = dir_q;
        cnt_nx  = cnt_q;
        ovf_evt = 1'b0;
        if (!center) dir_nx = DIR_UP;
        if (tick) begin
            if (!center) begin
                if (cnt_q >= top) begin
                    cnt_nx  = '0;
                    ovf_evt = 1'b1;
                end else begin
                    cnt_nx = cnt_q + CNT_W'(1);
                end
            end else begin
                unique case (dir_q)
                    DIR_UP: begin
                        if (cnt_q >= top) begin
                            cnt_nx  = cnt_q - CNT_W'(1);
                            dir_nx  = DIR_DOWN;
                            ovf_evt = 1'b1;
                        end else begin
                            cnt_nx = cnt_q + CNT_W'(1);
                        end
                    end
                    DIR_DOWN: begin
                        if (cnt_q == '0) begin
                            cnt_nx = CNT_W'(1);
                            dir_nx = DIR_UP;
                        end else begin
                            cnt_nx = cnt_q - CNT_W'(1);
                        end
                    end
                endcase
            end
        end
    end

    // R2: wrap lands on zero in up-count mode
    a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !center && cnt_q >= top) |=> cnt_q == '0);
    // R3: reaching the limit in up/down mode turns the direction
    a_r3_turn_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && center && dir_q == DIR_UP && cnt_q >= top) |=> dir_q == DIR_DOWN);
    // R9: no tick, no count change
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
endmodule

// File: rtl/tm_status.sv
module tm_status #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd,
    input  logic            wr,
    input  logic [7:0]      wdata,
    input  logic            ovf_evt,
    output logic [7:0]      rdata,
    output logic            flag,
    output logic            ie,
    output logic            center,
    output logic [1:0]      clk_sel,
    output logic [PS_W-1:0] ps
);
    import tm_pkg::*;
    flg_t st_q, st_nx;
    logic [6:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= FLG_CLEAR;
            ctrl_q <= '0;
        end else begin
            st_q <= st_nx;
            if (wr) ctrl_q <= wdata[6:0];
        end
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            FLG_CLEAR: if (ovf_evt) st_nx = FLG_SET;
            FLG_SET:   if (ovf_evt) st_nx = FLG_SET;
                       else if (rd) st_nx = FLG_ARMED;
            FLG_ARMED: if (ovf_evt) st_nx = FLG_SET;
                       else if (wr && !wdata[FLAG_BIT]) st_nx = FLG_CLEAR;
            default:   st_nx = FLG_CLEAR;
        endcase
    end

    always_comb begin
        flag    = (st_q != FLG_CLEAR);
        ie      = ctrl_q[6];
        center  = ctrl_q[5];
        clk_sel = ctrl_q[4:3];
        ps      = ctrl_q[PS_W-1:0];
        rdata   = {flag, ctrl_q};
    end

    // R6: an overflow always leaves the flag set
    a_r6_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> flag);
    // R7: without an overflow a clear flag stays clear
    a_r7_no_self_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !ovf_evt) |=> !flag);
    // R5: the flag only falls after a write of 0 to bit 7
    a_r5_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr && !wdata[FLAG_BIT])) |=> flag);
endmodule

// File: rtl/ovf_modulo_timer.sv
module ovf_modulo_timer #(
    parameter int CNT_W       = 16,
    parameter int PS_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [CNT_W-1:0] modulo,
    input  logic             fixed_tick,
    input  logic             ext_clk,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    import tm_pkg::*;
    logic            flag, ie, center, src_tick, tick, ovf_evt;
    logic [1:0]      clk_sel;
    logic [PS_W-1:0] ps;

    tm_status #(.PS_W(PS_W)) u_status (
        .clk(clk), .rst_n(rst_n), .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata),
        .ovf_evt(ovf_evt), .rdata(bus_rdata), .flag(flag), .ie(ie),
        .center(center), .clk_sel(clk_sel), .ps(ps)
    );

    tm_clk_sel #(.SYNC_STAGES(SYNC_STAGES)) u_clk_sel (
        .clk(clk), .rst_n(rst_n), .sel(clk_sel), .fixed_tick(fixed_tick),
        .ext_pin(ext_clk), .src_tick(src_tick)
    );

    tm_prescale #(.PS_W(PS_W)) u_prescale (
        .clk(clk), .rst_n(rst_n), .enable(clk_sel != SRC_OFF),
        .src_tick(src_tick), .ps(ps), .tick(tick)
    );

    tm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .center(center),
        .modulo(modulo), .count(count), .ovf_evt(ovf_evt)
    );

    assign irq = flag & ie;

    // R8: no request while the flag is clear
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[FLAG_BIT] |-> !irq);
endmodule

// File: tb/tb_ovf_modulo_timer.sv
module tb_ovf_modulo_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [15:0] modulo = 16'd3;
    logic        fixed_tick = 1'b0, ext_clk = 1'b0;
    logic [15:0] count;
    logic        irq;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 1'b0;

    ovf_modulo_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .modulo(modulo),
        .fixed_tick(fixed_tick), .ext_clk(ext_clk), .count(count), .irq(irq)
    );

    always #10 clk = ~clk;

    // reference model, written from the requirements
    logic        m_s1, m_s2, m_s3, m_dn, m_flag, m_arm;
    logic [6:0]  m_ctrl, m_pre;
    logic [15:0] m_cnt;

    function automatic logic [15:0] lim(input logic [15:0] m);
        return (m == 16'h0) ? 16'hFFFF : m;
    endfunction

    function automatic logic [7:0] exp_reg();
        return {m_flag, m_ctrl};
    endfunction

    always @(posedge clk) begin
        logic src, tk, ovf;
        logic [6:0] mask;
        logic [15:0] top;
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_s3 <= 0; m_dn <= 0; m_flag <= 0; m_arm <= 0;
            m_ctrl <= 0; m_pre <= 0; m_cnt <= 0;
        end else begin
            case (m_ctrl[4:3])
                2'b01:   src = 1'b1;
                2'b10:   src = fixed_tick;
                2'b11:   src = m_s2 & ~m_s3;
                default: src = 1'b0;
            endcase
            mask = 7'((8'd1 << m_ctrl[2:0]) - 8'd1);
            tk   = src && ((m_pre & mask) == mask);
            top  = lim(modulo);
            ovf  = 1'b0;
            m_s1 <= ext_clk; m_s2 <= m_s1; m_s3 <= m_s2;
            if (m_ctrl[4:3] == 2'b00) m_pre <= 0;
            else if (src) m_pre <= m_pre + 7'd1;
            if (!m_ctrl[5]) m_dn <= 1'b0;
            if (tk) begin
                if (!m_ctrl[5]) begin
                    if (m_cnt >= top) begin m_cnt <= 0; ovf = 1'b1; end
                    else m_cnt <= m_cnt + 16'd1;
                end else if (!m_dn) begin
                    if (m_cnt >= top) begin m_cnt <= m_cnt - 16'd1; m_dn <= 1'b1; ovf = 1'b1; end
                    else m_cnt <= m_cnt + 16'd1;
                end else begin
                    if (m_cnt == 0) begin m_cnt <= 16'd1; m_dn <= 1'b0; end
                    else m_cnt <= m_cnt - 16'd1;
                end
            end
            if (ovf) begin m_flag <= 1'b1; m_arm <= 1'b0; end
            else if (m_flag && !m_arm) begin if (bus_rd) m_arm <= 1'b1; end
            else if (m_arm && bus_wr && !bus_wdata[7]) begin m_flag <= 1'b0; m_arm <= 1'b0; end
            if (bus_wr) m_ctrl <= bus_wdata[6:0];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (time %0t)", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // one bus cycle: compare with the model, then drive the next inputs
    task automatic cyc(input logic rd, input logic wr, input logic [7:0] wd,
                       input logic fx, input logic ex);
        @(negedge clk);
        chk(m_ctrl[5] ? "R3 count" : "R2 count", 32'(count), 32'(m_cnt));
        chk("R11 register", 32'(bus_rdata), 32'(exp_reg()));
        chk("R8 irq", 32'(irq), 32'(m_flag & m_ctrl[6]));
        bus_rd = rd; bus_wr = wr; bus_wdata = wd; fixed_tick = fx; ext_clk = ex;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, ext_clk);
    endtask

    task automatic wait_flag();
        for (int i = 0; i < 200 && !bus_rdata[7]; i++) idle(1);
    endtask

    task automatic stop_clear();
        cyc(0, 1, 8'h00, 0, 0); cyc(1, 0, 8'h00, 0, 0); cyc(0, 1, 8'h00, 0, 0); idle(1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<190000 cycles", cycles);
            report();
        end
    end

    initial begin
        logic [15:0] c;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reg", 32'(bus_rdata), 32'h0);
        chk("R1 count", 32'(count), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2 / R5 / R7
        modulo = 16'd3;
        cyc(0, 1, 8'h08, 0, 0);
        wait_flag();
        chk("R2 wrap to zero", 32'(count), 32'h0);
        cyc(0, 1, 8'h00, 0, 0); idle(1);
        chk("R5 no read keeps flag", 32'(bus_rdata[7]), 32'h1);
        cyc(1, 0, 8'h00, 0, 0); cyc(0, 1, 8'h00, 0, 0); idle(1);
        chk("R5 read-write clears", 32'(bus_rdata[7]), 32'h0);
        cyc(0, 1, 8'h80, 0, 0); idle(1);
        chk("R7 write one ignored", 32'(bus_rdata), 32'h00);

        // R6 / R8
        modulo = 16'd1;
        cyc(0, 1, 8'h08, 0, 0);
        wait_flag();
        cyc(1, 0, 8'h00, 0, 0); idle(4);
        cyc(0, 1, 8'h48, 0, 0); idle(1);
        chk("R6 overflow cancels clear", 32'(bus_rdata[7]), 32'h1);
        chk("R8 irq with enable", 32'(irq), 32'h1);
        cyc(0, 1, 8'h40, 0, 0); cyc(1, 0, 8'h00, 0, 0); cyc(0, 1, 8'h40, 0, 0); idle(1);
        chk("R8 irq drops with flag", 32'(irq), 32'h0);

        // R3
        stop_clear();
        modulo = 16'd4;
        cyc(0, 1, 8'h28, 0, 0);
        for (int i = 0; i < 50 && count != 16'd4; i++) idle(1);
        idle(1);
        chk("R3 turn below limit", 32'(count), 32'd3);
        chk("R3 flag at turn", 32'(bus_rdata[7]), 32'h1);
        for (int i = 0; i < 50 && count != 16'd0; i++) idle(1);
        idle(1);
        chk("R3 turn up at zero", 32'(count), 32'd1);

        // R4
        stop_clear();
        modulo = 16'h0000;
        cyc(0, 1, 8'h08, 0, 0);
        for (int i = 0; i < 70000 && count != 16'hFFFF; i++) idle(1);
        chk("R4 reaches FFFF", 32'(count), 32'hFFFF);
        idle(1);
        chk("R4 wraps after FFFF", 32'(count), 32'h0);
        chk("R4 flag on wrap", 32'(bus_rdata[7]), 32'h1);

        // R10
        stop_clear();
        modulo = 16'h1000;
        cyc(0, 1, 8'h0A, 0, 0); idle(2);
        c = count; idle(4);
        chk("R10 divide by 4", 32'(count), 32'(c + 16'd1));

        // R9 fixed tick, off, external pin
        cyc(0, 1, 8'h10, 0, 0); idle(1);
        c = count;
        for (int i = 0; i < 5; i++) begin cyc(0, 0, 8'h00, 1, 0); idle(1); end
        idle(2);
        chk("R9 fixed tick source", 32'(count), 32'(c + 16'd5));
        cyc(0, 1, 8'h00, 0, 0); idle(1);
        c = count;
        for (int i = 0; i < 5; i++) cyc(0, 0, 8'h00, 1, 0);
        idle(2);
        chk("R9 off freezes", 32'(count), 32'(c));
        cyc(0, 1, 8'h18, 0, 0); idle(1);
        c = count;
        for (int i = 0; i < 4; i++) begin
            cyc(0, 0, 8'h00, 0, 1); idle(2);
            cyc(0, 0, 8'h00, 0, 0); idle(2);
        end
        idle(4);
        chk("R9 external edges", 32'(count), 32'(c + 16'd4));

        // constrained random
        modulo = 16'd5;
        for (int n = 0; n < 20000; n++) begin
            logic [7:0] wd;
            logic [1:0] cs;
            logic ex;
            cs = ($urandom % 4 == 0) ? 2'($urandom % 4) : 2'b01;
            wd = {1'($urandom), 1'($urandom), 1'($urandom), cs, 3'($urandom % 3)};
            ex = ($urandom % 5 == 0) ? ~ext_clk : ext_clk;
            if ($urandom % 500 == 0) modulo = 16'(($urandom % 15) + 1);
            cyc($urandom % 8 == 0, $urandom % 16 == 0, wd, 1'($urandom), ex);
        end
        idle(2);
        report();
    end
endmodule